// File: doc/BRIEF.md
# Cascaded Reload Event Counter

This block counts edges on an external input with two chained down-counting stages, an 8-bit prescaler and an 8-bit main stage. Either of two input pins can be chosen as the event source. The chosen pin goes through a two-flop synchronizer and an optional majority-free noise filter: a new level is accepted only after three consecutive samples agree. It then goes through an edge detector whose active polarity is programmable.

Each active edge decrements the prescaler while the counter runs. When the prescaler steps past zero it reloads and decrements the main stage. When the main stage steps past zero it reloads, raises a one-cycle interrupt request and, if enabled, inverts a pulse output. The event rate is therefore divided by (n+1)(m+1), where n and m are the two reload settings. A small write/read register port holds the run controls, the mode bits and the two count registers, and both live counts can be read back.

Top module: `evt_cascade_counter`

## Requirements
- R1: After reset the counter is stopped, both counts and both reload values are 0xFF, the mode register is 0, and irq_o and pulse_o are 0.
- R2: A write to address 2 (prescaler) or address 3 (main) sets both that stage's reload value and its live count to the written byte, whether or not the counter is running. If a decrement falls in the same cycle, the write wins.
- R3: Writing address 0 with bit0=1 and bit1=0 starts counting. Writing it with bit0=0 stops counting. While stopped, input edges leave both counts unchanged.
- R4: Writing address 0 with bit1=1 stops counting whatever the value of bit0.
- R5: Mode bit0 selects the active edge: 0 counts rising edges, 1 counts falling edges. Edges of the other polarity have no effect.
- R6: Mode bit1 selects the event source: 0 takes pin_a, 1 takes pin_b. The other pin has no effect.
- R7: Each active edge while running decrements the prescaler. A prescaler decrement at count 0 reloads it and decrements the main stage once. A main decrement at 0 reloads the main stage.
- R8: irq_o is high for one clock cycle for each main-stage underflow, which is once per (n+1)(m+1) active edges after both stages are loaded with n and m.
- R9: When mode bit2 is 1, pulse_o inverts on every main underflow. When mode bit2 is 0, pulse_o holds its level. Any write to the mode register sets pulse_o to 0.
- R10: Mode bits 4:3 control the input filter. 00 disables it, 01 samples every clock, 10 samples every 8 clocks and 11 samples every 32 clocks. With the filter on, a new level passes only after three consecutive samples agree, so a shorter pulse is dropped.
- R11: rd_data shows, one clock after rd_addr is presented, one of four values. Address 0 gives the running flag in bit0. Address 1 gives the mode bits in 4:0. Address 2 gives the live prescaler count. Address 3 gives the live main count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | Event source 0 (asynchronous) |
| pin_b | input | 1 | Event source 1 (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data |
| irq_o | output | 1 | One-cycle interrupt request per main underflow |
| pulse_o | output | 1 | Toggle output on main underflow |

## Verification
The assertions treat the two pins as asynchronous. They assume wr_addr and wr_data matter only in a cycle where wr_en is high, and that configuration can change between any two cycles. The bench keeps every event pulse wider than the synchronizer and filter delay, except for the glitches that are meant to be dropped. It sets both pins to their idle level and changes polarity or source only while the counter is stopped, so no configuration change adds a counted edge. Counts are checked only after the event stream has settled.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int ADDR_W = 2;
  localparam int A_CTRL_I = 0;
  localparam int A_MODE_I = 1;
  localparam int A_PRE_I  = 2;
  localparam int MODE_W   = 5;

  typedef enum logic [1:0] {
    FILT_OFF  = 2'd0,
    FILT_FAST = 2'd1,
    FILT_MID  = 2'd2,
    FILT_SLOW = 2'd3
  } filt_sel_e;

  typedef struct packed {
    filt_sel_e filt;
    logic      out_en;
    logic      pin_sel;
    logic      edge_fall;
  } mode_t;
endpackage

// File: rtl/ecc_in_cond.sv
module ecc_in_cond
  import ecc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int DIV_MID     = 8,
  parameter int DIV_SLOW    = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_a,
  input  logic      pin_b,
  input  logic      pin_sel,
  input  logic      edge_fall,
  input  filt_sel_e filt,
  output logic      evt_o
);
  localparam int TW = $clog2(DIV_SLOW + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   s_lvl;
  logic [TW-1:0]          div_q, div_lim;
  logic                   tick;
  logic [FILT_LEN-1:0]    samp_q, samp_nx;
  logic                   filt_q, prev_q;

  // source select ahead of one shared synchronizer
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], (pin_sel ? pin_b : pin_a)};
  end
  assign s_lvl = sync_q[SYNC_STAGES-1];

  // sample strobe for the filter
  always_comb begin
    div_lim = (filt == FILT_MID) ? TW'(DIV_MID - 1) : TW'(DIV_SLOW - 1);
  end

  always_ff @(posedge clk) begin
    if (rst || filt == FILT_OFF || filt == FILT_FAST) div_q <= '0;
    else if (div_q >= div_lim)                        div_q <= '0;
    else                                              div_q <= div_q + TW'(1);
  end

  assign tick = (filt == FILT_FAST) ||
                ((filt == FILT_MID || filt == FILT_SLOW) && div_q == '0);

  assign samp_nx = {samp_q[FILT_LEN-2:0], s_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= '0;
      filt_q <= 1'b0;
    end else if (filt == FILT_OFF) begin
      samp_q <= {FILT_LEN{s_lvl}};
      filt_q <= s_lvl;
    end else if (tick) begin
      samp_q <= samp_nx;
      if (&samp_nx)      filt_q <= 1'b1;
      else if (~|samp_nx) filt_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      evt_o  <= 1'b0;
    end else begin
      prev_q <= filt_q;
      evt_o  <= edge_fall ? (prev_q & ~filt_q) : (~prev_q & filt_q);
    end
  end

  // R10: with filtering on, the accepted level moves only on a sample strobe
  a_r10_level_on_tick: assert property (@(posedge clk) disable iff (rst)
    ($past(filt) != FILT_OFF && filt_q != $past(filt_q)) |-> $past(tick));

  // R10: a level change under filtering needs agreeing samples behind it
  a_r10_agree: assert property (@(posedge clk) disable iff (rst)
    ($past(filt) != FILT_OFF && $rose(filt_q)) |-> (&samp_q));
endmodule

// File: rtl/ecc_stage.sv
module ecc_stage #(
  parameter int            W       = 8,
  parameter logic [W-1:0]  RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q, rld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RST_VAL;
      rld_q <= RST_VAL;
    end else if (ld) begin
      cnt_q <= ld_val;
      rld_q <= ld_val;
    end else if (dec) begin
      cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign uf_o  = dec && !ld && (cnt_q == '0);

  // R2: a load lands in the live count on the next cycle
  a_r2_load_count: assert property (@(posedge clk) disable iff (rst)
    ld |=> cnt_q == $past(ld_val));

  // R7: a decrement above zero steps down by one
  a_r7_step: assert property (@(posedge clk) disable iff (rst)
    (dec && !ld && cnt_q != '0) |=> cnt_q == $past(cnt_q) - W'(1));

  // R7: an underflow restores the reload value
  a_r7_reload: assert property (@(posedge clk) disable iff (rst)
    uf_o |=> cnt_q == $past(rld_q));
endmodule

// File: rtl/evt_cascade_counter.sv
module evt_cascade_counter
  import ecc_pkg::*;
#(
  parameter int CW       = 8,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CW-1:0]     rd_data,
  output logic              irq_o,
  output logic              pulse_o
);
  localparam int NST = 2;

  logic          running;
  mode_t         mode_q;
  logic          evt;
  logic          ctrl_we, mode_we;
  logic [NST-1:0] ld_vec;
  logic [NST:0]   dec_chain;
  logic [CW-1:0]  cnt_a [NST];
  logic           main_uf;

  assign ctrl_we = wr_en && (int'(wr_addr) == A_CTRL_I);
  assign mode_we = wr_en && (int'(wr_addr) == A_MODE_I);

  always_comb begin
    for (int i = 0; i < NST; i++) ld_vec[i] = wr_en && (int'(wr_addr) == A_PRE_I + i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      mode_q  <= '0;
    end else begin
      if (ctrl_we) running <= wr_data[0] & ~wr_data[1];
      if (mode_we) mode_q  <= mode_t'(wr_data[MODE_W-1:0]);
    end
  end

  ecc_in_cond #(
    .SYNC_STAGES(2), .FILT_LEN(3), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) u_in (
    .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b),
    .pin_sel(mode_q.pin_sel), .edge_fall(mode_q.edge_fall),
    .filt(mode_q.filt), .evt_o(evt)
  );

  assign dec_chain[0] = evt & running;

  for (genvar i = 0; i < NST; i++) begin : g_stage
    ecc_stage #(.W(CW), .RST_VAL({CW{1'b1}})) u_stage (
      .clk(clk), .rst(rst), .ld(ld_vec[i]), .ld_val(wr_data),
      .dec(dec_chain[i]), .cnt_o(cnt_a[i]), .uf_o(dec_chain[i+1])
    );
  end

  assign main_uf = dec_chain[NST];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      irq_o <= main_uf;
      if (mode_we)                    pulse_o <= 1'b0;
      else if (main_uf && mode_q.out_en) pulse_o <= ~pulse_o;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      unique case (int'(rd_addr))
        A_CTRL_I: rd_data <= {{(CW-1){1'b0}}, running};
        A_MODE_I: rd_data <= {{(CW-MODE_W){1'b0}}, mode_q};
        A_PRE_I:  rd_data <= cnt_a[0];
        default:  rd_data <= cnt_a[NST-1];
      endcase
    end
  end

  // R3: no prescaler movement while stopped except through a load
  a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
    (!running && !ld_vec[0]) |=> $stable(cnt_a[0]));

  // R4: a forced stop leaves the counter idle on the next cycle
  a_r4_force_stop: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && wr_data[1]) |=> !running);

  // R8: every request traces back to a main underflow
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(main_uf));

  // R9: the pulse output changes only on an enabled underflow or a mode write
  a_r9_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    (pulse_o != $past(pulse_o)) |-> $past((main_uf && mode_q.out_en) || mode_we));

  // R7: the main stage moves only on a prescaler underflow or a load
  a_r7_main_cause: assert property (@(posedge clk) disable iff (rst)
    (!dec_chain[1] && !ld_vec[NST-1]) |=> $stable(cnt_a[NST-1]));
endmodule

// File: tb/sim_evt_cascade_counter.sv
`timescale 1ns/1ps
module sim_evt_cascade_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_a = 1'b0, pin_b = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq_o, pulse_o;

  int n_chk = 0, n_bad = 0, irq_seen = 0;
  bit done = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  evt_cascade_counter u0 (
    .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .pulse_o(pulse_o)
  );

  always @(negedge clk) if (!rst && irq_o) irq_seen++;

  typedef struct packed {
    logic       fall;
    logic       oe;
    logic [7:0] n, m, ev, x_pre, x_main, x_irq;
    logic       x_pulse;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b1, 8'd0, 8'd0, 8'd5,  8'd0, 8'd0, 8'd5, 1'b1},
    '{1'b0, 1'b1, 8'd2, 8'd1, 8'd7,  8'd1, 8'd1, 8'd1, 1'b1},
    '{1'b1, 1'b0, 8'd3, 8'd2, 8'd12, 8'd3, 8'd2, 8'd1, 1'b0},
    '{1'b1, 1'b1, 8'd1, 8'd3, 8'd5,  8'd0, 8'd1, 8'd0, 1'b0},
    '{1'b0, 1'b1, 8'd4, 8'd0, 8'd9,  8'd0, 8'd0, 8'd1, 1'b1},
    '{1'b1, 1'b0, 8'd0, 8'd4, 8'd3,  8'd0, 8'd1, 8'd0, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  // pulses away from the idle level `lvl` on pin a or b
  task automatic pulses(input int cnt, input bit on_b, input bit lvl, input int hi, input int lo);
    for (int k = 0; k < cnt; k++) begin
      @(negedge clk); if (on_b) pin_b = ~lvl; else pin_a = ~lvl;
      idle(hi);
      if (on_b) pin_b = lvl; else pin_a = lvl;
      idle(lo);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);
    // R1 / R11: reset state through the read port
    rd(2'd0, rv); check("R1 ctrl", rv, 8'h00);
    rd(2'd1, rv); check("R1 mode", rv, 8'h00);
    rd(2'd2, rv); check("R1 pre", rv, 8'hFF);
    rd(2'd3, rv); check("R1 main", rv, 8'hFF);
    check("R1 irq", {7'd0, irq_o}, 8'd0);
    check("R1 pulse", {7'd0, pulse_o}, 8'd0);

    // table walk: R5 polarity, R7 cascade, R8 irq count, R9 toggle
    for (int v = 0; v < 6; v++) begin
      pin_a = VECS[v].fall; pin_b = VECS[v].fall;
      idle(8);
      wr(2'd1, {5'd0, VECS[v].oe, 1'b0, VECS[v].fall});
      wr(2'd2, VECS[v].n);
      wr(2'd3, VECS[v].m);
      idle(2);
      irq_seen = 0;
      wr(2'd0, 8'h01);
      pulses(int'(VECS[v].ev), 1'b0, VECS[v].fall, 4, 4);
      idle(8);
      wr(2'd0, 8'h00);
      rd(2'd2, rv); check($sformatf("R7 pre v%0d", v), rv, VECS[v].x_pre);
      rd(2'd3, rv); check($sformatf("R7 main v%0d", v), rv, VECS[v].x_main);
      check($sformatf("R8 irq v%0d", v), 8'(irq_seen), VECS[v].x_irq);
      check($sformatf("R9 pulse v%0d", v), {7'd0, pulse_o}, {7'd0, VECS[v].x_pulse});
      // R5: opposite-polarity return edges did not count (covered by counts above)
    end

    // R3: stopped counter ignores edges; R2 load while stopped
    pin_a = 1'b0; pin_b = 1'b0; idle(8);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'd9);
    rd(2'd2, rv); check("R2 load stopped", rv, 8'd9);
    pulses(3, 1'b0, 1'b0, 4, 4); idle(8);
    rd(2'd2, rv); check("R3 stopped no count", rv, 8'd9);

    // R3 start, R11 running flag, R2 load while running
    wr(2'd0, 8'h01);
    rd(2'd0, rv); check("R11 ctrl running", rv, 8'h01);
    pulses(2, 1'b0, 1'b0, 4, 4); idle(8);
    rd(2'd2, rv); check("R3 counts when started", rv, 8'd7);
    wr(2'd2, 8'd5);
    rd(2'd2, rv); check("R2 load running count", rv, 8'd5);
    pulses(6, 1'b0, 1'b0, 4, 4); idle(8);
    rd(2'd2, rv); check("R2 load running reload", rv, 8'd5);

    // R4: forced stop overrides start bit
    wr(2'd0, 8'h03);
    rd(2'd0, rv); check("R4 forced stop flag", rv, 8'h00);
    pulses(2, 1'b0, 1'b0, 4, 4); idle(8);
    rd(2'd2, rv); check("R4 forced stop count", rv, 8'd5);

    // R6: source select
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h01);
    pulses(2, 1'b0, 1'b0, 4, 4); idle(8);
    rd(2'd2, rv); check("R6 unselected pin", rv, 8'd5);
    pulses(2, 1'b1, 1'b0, 4, 4); idle(8);
    rd(2'd2, rv); check("R6 selected pin", rv, 8'd3);

    // R11: mode readback
    wr(2'd1, 8'h16);
    rd(2'd1, rv); check("R11 mode readback", rv, 8'h16);

    // R9: mode write clears a high pulse output
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h04);
    wr(2'd2, 8'd0); wr(2'd3, 8'd0);
    wr(2'd0, 8'h01);
    pulses(1, 1'b0, 1'b0, 4, 4); idle(8);
    check("R9 toggled high", {7'd0, pulse_o}, 8'd1);
    wr(2'd1, 8'h04);
    idle(1);
    check("R9 mode write clears", {7'd0, pulse_o}, 8'd0);

    // R10: filter, sample every clock
    wr(2'd1, 8'h08);
    wr(2'd2, 8'd10); wr(2'd3, 8'd50);
    idle(8);
    pulses(1, 1'b0, 1'b0, 2, 8); idle(8);
    rd(2'd2, rv); check("R10 fast glitch dropped", rv, 8'd10);
    pulses(1, 1'b0, 1'b0, 6, 6); idle(8);
    rd(2'd2, rv); check("R10 fast pulse passes", rv, 8'd9);

    // R10: filter, sample every 32 clocks
    wr(2'd1, 8'h18);
    idle(80);
    pulses(1, 1'b0, 1'b0, 10, 80); idle(8);
    rd(2'd2, rv); check("R10 slow glitch dropped", rv, 8'd9);
    pulses(1, 1'b0, 1'b0, 120, 120); idle(8);
    rd(2'd2, rv); check("R10 slow pulse passes", rv, 8'd8);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule